// File: doc/BRIEF.md
# Infrared serial line shim

This block sits between a UART's serial bit stream and an infrared transceiver. On the transmit side it watches the UART output and follows the 16x baud tick. Each 0 bit becomes a short light pulse, and each 1 bit sends nothing. The pulse lasts either three 16x ticks or a fixed number of system clocks. The fixed count is a parameter and stands for 1.6 µs. The pulse level can be inverted. On the receive side the transceiver output passes through a two-stage synchronizer. Each rising edge of the active level then opens a 16-tick low window on the line returned to the UART receiver. This rebuilds an NRZ stream.

Transmit and receive each have their own mode bit. When a mode bit is clear, that direction passes the signal straight through. When receive decoding and transmit encoding are both on, edges that arrive while the local emitter is pulsing are dropped. This keeps the block's own light from echoing back into the receiver. UART framing, baud generation and the bit sampling inside the UART are handled elsewhere.

Top module: `sir_phy`

## Requirements
- R1: After reset, with transmit encoding on and no inversion, `ir_tx` is 0 and, with receive decoding on, `uart_rxd` is 1.
- R2: With `tx_ir_en` = 0, `ir_tx` equals `uart_txd` in the same cycle.
- R3: With `tx_ir_en` = 1, a bit starts on a `baud_tick16` cycle where `uart_txd` is 0 and either it was 1 at the previous tick or 16 ticks have passed since the last start. Every start produces exactly one pulse. A 1 bit produces none.
- R4: With `fixed_width_sel` = 0, the pulse is active from the clock after the start tick until the clock after the third following tick.
- R5: With `fixed_width_sel` = 1, the pulse is active for exactly `PULSE_CLKS` clocks after the start tick.
- R6: With `tx_pulse_inv` = 0 the pulse is 1 on an idle level of 0; with `tx_pulse_inv` = 1 the pulse is 0 on an idle level of 1.
- R7: With `rx_ir_en` = 0, `uart_rxd` equals `ir_rx` in the same cycle.
- R8: With `rx_ir_en` = 1, a rising edge of the active level goes low on `uart_rxd` three clocks after `ir_rx` changes. The line then stays low until 16 further ticks have passed.
- R9: With `rx_pulse_inv` = 0 a high level on `ir_rx` is active; with `rx_pulse_inv` = 1 a low level is active.
- R10: A new edge during the low window restarts the full 16-tick count. An edge and a tick in the same cycle load the full count.
- R11: While `tx_ir_en` = 1 and the encoder pulse is active, edges seen on `ir_rx` are ignored and do not pull `uart_rxd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick16 | input | 1 | One-clock strobe at 16 times the bit rate |
| tx_ir_en | input | 1 | 1 = encode transmit as pulses, 0 = pass through |
| rx_ir_en | input | 1 | 1 = decode receive pulses, 0 = pass through |
| fixed_width_sel | input | 1 | 0 = three-tick pulse, 1 = fixed-clock pulse |
| tx_pulse_inv | input | 1 | Inverts the transmitted pulse level |
| rx_pulse_inv | input | 1 | Inverts the level treated as active on receive |
| uart_txd | input | 1 | NRZ serial output of the UART |
| ir_tx | output | 1 | Drive to the infrared emitter |
| ir_rx | input | 1 | Output of the infrared detector |
| uart_rxd | output | 1 | NRZ serial input to the UART |

## Verification
Two things can fall in the same cycle: a synchronized edge arriving in the decoder and a 16x tick that would count the hold window down. The bench sweeps the pulse start across every clock of the tick period. One of those positions lands exactly on a tick, and the measured low time must then equal sixteen full tick periods. The second collision is an incoming edge while the local emitter is pulsing. The bench provokes it by looping `ir_tx` back into `ir_rx` during a whole frame and expects `uart_rxd` never to fall. A per-clock reference model judges both cases, along with every other cycle.

// File: rtl/sir_pkg.sv
package sir_pkg;

  // A new bit period opens on a tick where the UART line is low and the
  // line was high at the last tick, or the previous low bit has run its span.
  function automatic logic bit_opens(logic line_now, logic line_before,
                                     logic span_done);
    return !line_now && (line_before || span_done);
  endfunction

  // Drive level of the emitter in encoding mode.
  function automatic logic emit_level(logic pulsing, logic invert);
    return pulsing ^ invert;
  endfunction

  // Whether a detector sample counts as light, given the receive polarity.
  function automatic logic is_lit(logic sample, logic invert);
    return sample ^ invert;
  endfunction

endpackage

// File: rtl/sir_encoder.sv
module sir_encoder #(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_TICKS   = 3,
  parameter int PULSE_CLKS    = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic txd,
  input  logic width_fixed,
  output logic pulse_active
);
  localparam int PW = $clog2(TICKS_PER_BIT);
  localparam int TW = $clog2(PULSE_TICKS + 1);
  localparam int CW = $clog2(PULSE_CLKS + 1);
  localparam logic [PW-1:0] LAST_PHASE = PW'(TICKS_PER_BIT - 1);

  logic [PW-1:0] phase_q;
  logic          txd_last_q;
  logic [TW-1:0] tick_left_q;
  logic [CW-1:0] clk_left_q;
  logic          bit_start;

  assign bit_start = tick && sir_pkg::bit_opens(txd, txd_last_q, phase_q == LAST_PHASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= LAST_PHASE;
      txd_last_q <= 1'b1;
    end else if (tick) begin
      txd_last_q <= txd;
      if (bit_start || phase_q == LAST_PHASE) phase_q <= '0;
      else                                    phase_q <= phase_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_left_q <= '0;
    end else if (bit_start) begin
      tick_left_q <= TW'(PULSE_TICKS);
    end else if (tick && tick_left_q != '0) begin
      tick_left_q <= tick_left_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_left_q <= '0;
    end else if (bit_start) begin
      clk_left_q <= CW'(PULSE_CLKS);
    end else if (clk_left_q != '0) begin
      clk_left_q <= clk_left_q - CW'(1);
    end
  end

  assign pulse_active = width_fixed ? (clk_left_q != '0) : (tick_left_q != '0);

  a_r3_start_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> pulse_active);

  a_r4_tick_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!width_fixed && tick && tick_left_q == TW'(1) && !bit_start)
      |=> (!pulse_active || width_fixed));

  a_r5_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (width_fixed && clk_left_q > CW'(1) && !bit_start)
      |=> (pulse_active || !width_fixed));

endmodule

// File: rtl/sir_decoder.sv
module sir_decoder #(
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ir_in,
  input  logic invert,
  input  logic suppress,
  output logic rxd
);
  localparam int HW = $clog2(TICKS_PER_BIT + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lit_now;
  logic                   lit_prev_q;
  logic                   edge_raw;
  logic                   edge_take;
  logic [HW-1:0]          hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], ir_in};
  end

  assign lit_now   = sir_pkg::is_lit(sync_q[SYNC_STAGES-1], invert);
  assign edge_raw  = lit_now && !lit_prev_q;
  assign edge_take = edge_raw && !suppress;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lit_prev_q <= 1'b1;
    else        lit_prev_q <= lit_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (edge_take) begin
      hold_q <= HW'(TICKS_PER_BIT);
    end else if (tick && hold_q != '0) begin
      hold_q <= hold_q - HW'(1);
    end
  end

  assign rxd = (hold_q == '0);

  a_r8_edge_loads: assert property (@(posedge clk) disable iff (!rst_n)
    edge_take |=> !rxd);

  a_r10_edge_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_take && tick) |=> (hold_q == HW'(TICKS_PER_BIT)));

  a_r11_echo_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (suppress && rxd) |=> rxd);

endmodule

// File: rtl/sir_phy.sv
module sir_phy #(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_TICKS   = 3,
  parameter int PULSE_CLKS    = 400,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick16,
  input  logic tx_ir_en,
  input  logic rx_ir_en,
  input  logic fixed_width_sel,
  input  logic tx_pulse_inv,
  input  logic rx_pulse_inv,
  input  logic uart_txd,
  output logic ir_tx,
  input  logic ir_rx,
  output logic uart_rxd
);
  logic enc_pulse;
  logic echo_gate;
  logic dec_rxd;

  sir_encoder #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .PULSE_TICKS  (PULSE_TICKS),
    .PULSE_CLKS   (PULSE_CLKS)
  ) u_enc (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (baud_tick16),
    .txd         (uart_txd),
    .width_fixed (fixed_width_sel),
    .pulse_active(enc_pulse)
  );

  assign echo_gate = tx_ir_en && enc_pulse;

  sir_decoder #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick16),
    .ir_in   (ir_rx),
    .invert  (rx_pulse_inv),
    .suppress(echo_gate),
    .rxd     (dec_rxd)
  );

  assign ir_tx    = tx_ir_en ? sir_pkg::emit_level(enc_pulse, tx_pulse_inv) : uart_txd;
  assign uart_rxd = rx_ir_en ? dec_rxd : ir_rx;

  a_r1_rx_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> dec_rxd);

endmodule

// File: tb/sim_sir_phy.sv
module sim_sir_phy;
  localparam int TICK_DIV   = 32;
  localparam int PULSE_CLKS = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick16 = 1'b0;
  logic tx_ir_en = 1'b1, rx_ir_en = 1'b1, fixed_width_sel = 1'b0;
  logic tx_pulse_inv = 1'b0, rx_pulse_inv = 1'b0;
  logic uart_txd = 1'b1;
  logic ext_ir = 1'b0, echo_q = 1'b0, loop_en = 1'b0;
  logic ir_line, ir_tx, uart_rxd;

  int tests = 0, fails = 0;
  bit done = 0, cmp_en = 0;
  string tag_tx = "R1", tag_rx = "R1";
  int div = 0;

  assign ir_line = loop_en ? echo_q : ext_ir;

  sir_phy #(.PULSE_CLKS(PULSE_CLKS)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick16(baud_tick16), .tx_ir_en(tx_ir_en),
    .rx_ir_en(rx_ir_en), .fixed_width_sel(fixed_width_sel),
    .tx_pulse_inv(tx_pulse_inv), .rx_pulse_inv(rx_pulse_inv),
    .uart_txd(uart_txd), .ir_tx(ir_tx), .ir_rx(ir_line), .uart_rxd(uart_rxd));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin div = 0; baud_tick16 = 1'b0; end
    else begin
      div = (div == TICK_DIV - 1) ? 0 : div + 1;
      baud_tick16 = (div == 0);
    end
    echo_q = ir_tx;
  end

  // Reference model: elapsed-time bookkeeping with integers.
  int  m_phase, m_ticks, m_cyc, m_hold;
  bit  m_last, m_s0, m_s1, m_prev, m_lit, m_edge, m_start;

  function automatic bit enc_on();
    return fixed_width_sel ? (m_cyc < PULSE_CLKS) : (m_ticks < 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 15; m_last = 1; m_ticks = 1000; m_cyc = 1000000; m_hold = 0;
      m_s0 = 0; m_s1 = 0; m_prev = 1;
    end else begin
      m_lit  = m_s1 ^ rx_pulse_inv;
      m_edge = m_lit && !m_prev && !(tx_ir_en && enc_on());
      if (m_edge) m_hold = 16;
      else if (baud_tick16 && m_hold > 0) m_hold = m_hold - 1;
      m_prev = m_lit; m_s1 = m_s0; m_s0 = ir_line;
      m_start = baud_tick16 && !uart_txd && (m_last || m_phase == 15);
      if (baud_tick16) begin
        m_last  = uart_txd;
        m_phase = m_start ? 0 : (m_phase + 1) % 16;
      end
      if (m_start) begin m_ticks = 0; m_cyc = 0; end
      else begin
        if (baud_tick16 && m_ticks < 1000) m_ticks = m_ticks + 1;
        if (m_cyc < 1000000) m_cyc = m_cyc + 1;
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input bit ok, input int act, input int exp, input string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  int  pulse_cnt = 0, low_cnt = 0;
  logic tx_prev = 1'b0;

  always @(negedge clk) begin
    #1;
    if (cmp_en) begin
      check(tag_tx, ir_tx, tx_ir_en ? (enc_on() ^ tx_pulse_inv) : uart_txd, "ir_tx per-cycle");
      check(tag_rx, uart_rxd, rx_ir_en ? (m_hold == 0) : ir_line, "uart_rxd per-cycle");
      if (ir_tx !== tx_prev && ir_tx === !tx_pulse_inv) pulse_cnt++;
      if (uart_rxd === 1'b0) low_cnt++;
    end
    tx_prev = ir_tx;
  end

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (baud_tick16) k++;
    end
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b);
    uart_txd = 1'b0; wait_ticks(16);
    for (int i = 0; i < 8; i++) begin uart_txd = b[i]; wait_ticks(16); end
    uart_txd = 1'b1; wait_ticks(16);
    wait_ticks(8);
  endtask

  task automatic ext_pulse(input int clks);
    ext_ir = !rx_pulse_inv;
    repeat (clks) @(negedge clk);
    ext_ir = rx_pulse_inv;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: idle levels straight after reset
    check("R1", ir_tx, 1'b0, "ir_tx after reset");
    check("R1", uart_rxd, 1'b1, "uart_rxd after reset");
    cmp_en = 1;
    wait_ticks(2);

    // R2 / R7: pass-through directions
    tx_ir_en = 0; rx_ir_en = 0; tag_tx = "R2"; tag_rx = "R7";
    uart_txd = 1'b0; ext_ir = 1'b1; #1;
    check("R2", ir_tx, 1'b0, "pass-through low");
    check("R7", uart_rxd, 1'b1, "pass-through high");
    @(negedge clk); uart_txd = 1'b1; ext_ir = 1'b0; #1;
    check("R2", ir_tx, 1'b1, "pass-through high");
    check("R7", uart_rxd, 1'b0, "pass-through low");
    @(negedge clk); ext_ir = 1'b0;
    wait_ticks(20);
    tx_ir_en = 1; rx_ir_en = 1;

    // R3 / R4 / R6: three-tick pulses, both polarities
    tag_tx = "R4"; tag_rx = "R8";
    pulse_cnt = 0; send_frame(8'hA5);
    check_int("R3", pulse_cnt == 5, pulse_cnt, 5, "pulses for 0xA5 frame");
    tx_pulse_inv = 1; tag_tx = "R6";
    wait_ticks(4);
    pulse_cnt = 0; send_frame(8'h00);
    check_int("R6", pulse_cnt == 9, pulse_cnt, 9, "inverted pulses for 0x00 frame");
    tx_pulse_inv = 0;
    wait_ticks(4);

    // R5: fixed clock-count pulses
    fixed_width_sel = 1; tag_tx = "R5";
    pulse_cnt = 0; send_frame(8'h3C);
    check_int("R5", pulse_cnt == 5, pulse_cnt, 5, "fixed-width pulses for 0x3C frame");
    fixed_width_sel = 0;
    wait_ticks(20);

    // R8 / R10: decode sweep across every clock of the tick period
    tag_tx = "R3"; tag_rx = "R10";
    for (int off = 0; off < TICK_DIV; off++) begin
      wait_ticks(1);
      repeat (off) @(negedge clk);
      low_cnt = 0;
      ext_pulse(20);
      wait_ticks(18);
      check_int("R8", low_cnt > 15 * TICK_DIV && low_cnt <= 16 * TICK_DIV,
                low_cnt, 16 * TICK_DIV, "low window length");
    end

    // R10: retrigger inside the window
    wait_ticks(2);
    low_cnt = 0;
    ext_pulse(20); wait_ticks(8); ext_pulse(20); wait_ticks(20);
    check_int("R10", low_cnt > 17 * TICK_DIV, low_cnt, 24 * TICK_DIV, "retriggered window");

    // R9: inverted receive polarity
    tag_rx = "R9";
    rx_ir_en = 0; ext_ir = 1'b1; rx_pulse_inv = 1;
    wait_ticks(18);
    rx_ir_en = 1; #1;
    check("R9", uart_rxd, 1'b1, "idle with inverted receive");
    @(negedge clk);
    low_cnt = 0;
    ext_pulse(20); wait_ticks(18);
    check_int("R9", low_cnt > 15 * TICK_DIV, low_cnt, 16 * TICK_DIV, "low pulse decoded");
    rx_ir_en = 0; ext_ir = 1'b0; rx_pulse_inv = 0;
    wait_ticks(18);
    rx_ir_en = 1;

    // R11: local emitter looped back must not reach the receiver
    tag_tx = "R11"; tag_rx = "R11";
    @(negedge clk); loop_en = 1;
    wait_ticks(2);
    low_cnt = 0;
    send_frame(8'h55);
    check_int("R11", low_cnt == 0, low_cnt, 0, "echo low cycles");
    loop_en = 0;
    wait_ticks(4);

    cmp_en = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule